// File: doc/BRIEF.md
# CPU Low-Power Status Register

This block is one CPU's power-control register. It holds three deep-sleep selection bits, one per power domain, and one bit that keeps the third domain running whatever the CPUs do. It also holds four low-power flags that hardware sets: a stop flag, a system standby flag, and one standby flag for each of the first two domains. The power sequencer raises a one-cycle event pulse when one of these states is entered, and the matching flag latches.

Software reads all of this through one readback word. It clears the flags by writing 1 to a command bit, which acts only in the cycle of the write and always reads back as 0. The flags answer to different reset classes. A power-on reset clears everything. A system reset clears the selections and every flag except the system standby flag. A domain standby flag stays set while its domain is still in standby. A clear command issued in that state is dropped for that flag and is not replayed later.

Top module: `cpupwr_lp_status`

## Requirements
- R1: While `rst_por` is high, the register is cleared, and from the next cycle on `rd_data` reads all zeros, including the system standby flag.
- R2: A cycle with `rst_sys` high and `rst_por` low clears the selection bits 0..2, the keep-running bit 11, the stop flag (bit 5) and both domain standby flags (bits 7 and 8).
- R3: A system reset leaves the system standby flag (bit 6) at its previous value.
- R4: A write loads bits 0..2 (deep-sleep select for domains 1..3) and bit 11 (keep domain 3 running) from `wr_data`. These also drive `dsel_o` and `d3_run_o`. Written values in bits 5..8 and in every other unused bit have no effect on the readback.
- R5: An event pulse sets its flag from the next cycle: `evt_stop` sets bit 5, `evt_sbsys` sets bit 6, and `evt_sbdom[i]` sets bit 7+i.
- R6: A write with bit 9 set clears the stop flag and the system standby flag in the next cycle.
- R7: A clear command clears domain standby flag i only if `dom_in_sb[i]` is low in the cycle of the write. Otherwise the command is dropped for that flag and has no later effect.
- R8: When a flag's set event and a clear command fall in the same cycle, the flag ends up set.
- R9: Bit 9 of `rd_data` always reads 0.
- R10: Event pulses arriving in a cycle with either reset high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por | input | 1 | Power-on reset, synchronous, active high |
| rst_sys | input | 1 | System reset, synchronous, active high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| evt_stop | input | 1 | Stop-entry event pulse |
| evt_sbsys | input | 1 | System standby entry event pulse |
| evt_sbdom | input | 2 | Per-domain standby entry event pulses |
| dom_in_sb | input | 2 | Level: the domain is currently in standby |
| rd_data | output | 32 | Readback word |
| dsel_o | output | 3 | Deep-sleep selection per domain |
| d3_run_o | output | 1 | Keep domain 3 running |

## Verification
On every cycle the assertions check the effects of each reset class, that events win over clears, that a domain flag holds while its domain is in standby, that the write data reaches the selection bits, and that the command bit reads 0. Only the bench's scenarios can show that a dropped clear is not replayed after the domain leaves standby. The same holds for the flag values and the unused bits after several writes in a row, and for the system standby flag surviving one reset class and falling to the other. A behavioural model predicts every output on every cycle.

// File: rtl/cpupwr_pkg.sv
package cpupwr_pkg;
    localparam int REG_W    = 32;
    localparam int NUM_DS   = 3;
    localparam int NUM_DSB  = 2;

    // bit positions of the readback word
    localparam int POS_DS   = 0;
    localparam int POS_STOP = 5;
    localparam int POS_SBS  = 6;
    localparam int POS_SBD  = 7;
    localparam int POS_CLR  = 9;
    localparam int POS_RUN  = 11;

    typedef enum logic [0:0] {
        RC_SYS = 1'b0,   // cleared by any reset
        RC_POR = 1'b1    // cleared only by power-on reset
    } rst_class_e;

    typedef struct packed {
        logic              run;
        logic [NUM_DS-1:0] ds;
    } ctrl_t;

    typedef struct packed {
        logic               stop;
        logic               sbs;
        logic [NUM_DSB-1:0] sbd;
    } flags_t;

    function automatic logic [REG_W-1:0] pack_read(ctrl_t c, flags_t f);
        logic [REG_W-1:0] w;
        w = '0;
        w[POS_DS +: NUM_DS]   = c.ds;
        w[POS_RUN]            = c.run;
        w[POS_STOP]           = f.stop;
        w[POS_SBS]            = f.sbs;
        w[POS_SBD +: NUM_DSB] = f.sbd;
        return w;
    endfunction
endpackage

// File: rtl/cpupwr_wr_decode.sv
module cpupwr_wr_decode
    import cpupwr_pkg::*;
(
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic             ld_ctrl,
    output ctrl_t            ctrl_new,
    output logic             clr_cmd
);
    always_comb begin
        ld_ctrl      = wr_en;
        ctrl_new.ds  = wr_data[POS_DS +: NUM_DS];
        ctrl_new.run = wr_data[POS_RUN];
        clr_cmd      = wr_en & wr_data[POS_CLR];
    end
endmodule

// File: rtl/cpupwr_ctrl_reg.sv
module cpupwr_ctrl_reg
    import cpupwr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_por,
    input  logic  rst_sys,
    input  logic  ld_ctrl,
    input  ctrl_t ctrl_new,
    output ctrl_t ctrl_q
);
    always_ff @(posedge clk) begin
        if (rst_por || rst_sys) begin
            ctrl_q <= '0;
        end else if (ld_ctrl) begin
            ctrl_q <= ctrl_new;
        end
    end
endmodule

// File: rtl/cpupwr_flag_cell.sv
module cpupwr_flag_cell
    import cpupwr_pkg::*;
#(
    parameter rst_class_e RCLASS = RC_SYS
) (
    input  logic clk,
    input  logic rst_por,
    input  logic rst_sys,
    input  logic set_i,
    input  logic clr_i,
    input  logic clr_ok_i,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst_por) begin
            q <= 1'b0;
        end else if (rst_sys) begin
            if (RCLASS == RC_SYS) q <= 1'b0;
        end else if (set_i) begin
            q <= 1'b1;
        end else if (clr_i && clr_ok_i) begin
            q <= 1'b0;
        end
    end
endmodule

// File: rtl/cpupwr_flag_bank.sv
module cpupwr_flag_bank
    import cpupwr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_por,
    input  logic               rst_sys,
    input  logic               clr_cmd,
    input  logic               evt_stop,
    input  logic               evt_sbsys,
    input  logic [NUM_DSB-1:0] evt_sbdom,
    input  logic [NUM_DSB-1:0] dom_in_sb,
    output flags_t             flags_q
);
    cpupwr_flag_cell #(.RCLASS(RC_SYS)) u_stop (
        .clk(clk), .rst_por(rst_por), .rst_sys(rst_sys),
        .set_i(evt_stop), .clr_i(clr_cmd), .clr_ok_i(1'b1),
        .q(flags_q.stop)
    );

    cpupwr_flag_cell #(.RCLASS(RC_POR)) u_sbs (
        .clk(clk), .rst_por(rst_por), .rst_sys(rst_sys),
        .set_i(evt_sbsys), .clr_i(clr_cmd), .clr_ok_i(1'b1),
        .q(flags_q.sbs)
    );

    for (genvar i = 0; i < NUM_DSB; i++) begin : g_dom
        cpupwr_flag_cell #(.RCLASS(RC_SYS)) u_sbd (
            .clk(clk), .rst_por(rst_por), .rst_sys(rst_sys),
            .set_i(evt_sbdom[i]), .clr_i(clr_cmd), .clr_ok_i(!dom_in_sb[i]),
            .q(flags_q.sbd[i])
        );
    end
endmodule

// File: rtl/cpupwr_lp_status.sv
module cpupwr_lp_status
    import cpupwr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_por,
    input  logic               rst_sys,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               evt_stop,
    input  logic               evt_sbsys,
    input  logic [NUM_DSB-1:0] evt_sbdom,
    input  logic [NUM_DSB-1:0] dom_in_sb,
    output logic [REG_W-1:0]   rd_data,
    output logic [NUM_DS-1:0]  dsel_o,
    output logic               d3_run_o
);
    logic   ld_ctrl;
    logic   clr_cmd;
    ctrl_t  ctrl_new;
    ctrl_t  ctrl_q;
    flags_t flags_q;

    cpupwr_wr_decode u_dec (
        .wr_en(wr_en), .wr_data(wr_data),
        .ld_ctrl(ld_ctrl), .ctrl_new(ctrl_new), .clr_cmd(clr_cmd)
    );

    cpupwr_ctrl_reg u_ctrl (
        .clk(clk), .rst_por(rst_por), .rst_sys(rst_sys),
        .ld_ctrl(ld_ctrl), .ctrl_new(ctrl_new), .ctrl_q(ctrl_q)
    );

    cpupwr_flag_bank u_flags (
        .clk(clk), .rst_por(rst_por), .rst_sys(rst_sys),
        .clr_cmd(clr_cmd), .evt_stop(evt_stop), .evt_sbsys(evt_sbsys),
        .evt_sbdom(evt_sbdom), .dom_in_sb(dom_in_sb), .flags_q(flags_q)
    );

    always_comb begin
        rd_data  = pack_read(ctrl_q, flags_q);
        dsel_o   = ctrl_q.ds;
        d3_run_o = ctrl_q.run;
    end
endmodule

// File: rtl/cpupwr_lp_status_chk.sv
module cpupwr_lp_status_chk
    import cpupwr_pkg::*;
(
    input logic               clk,
    input logic               rst_por,
    input logic               rst_sys,
    input logic               wr_en,
    input logic [REG_W-1:0]   wr_data,
    input logic               evt_stop,
    input logic               evt_sbsys,
    input logic [NUM_DSB-1:0] evt_sbdom,
    input logic [NUM_DSB-1:0] dom_in_sb,
    input logic [REG_W-1:0]   rd_data
);
    a_r1_por_clears: assert property (@(posedge clk)
        rst_por |=> rd_data == '0);

    a_r2_sys_clears: assert property (@(posedge clk) disable iff (rst_por)
        rst_sys |=> (rd_data[POS_DS +: NUM_DS] == '0) && !rd_data[POS_STOP]
                    && !rd_data[POS_RUN] && (rd_data[POS_SBD +: NUM_DSB] == '0));

    a_r3_sys_keeps_sbs: assert property (@(posedge clk) disable iff (rst_por)
        rst_sys |=> rd_data[POS_SBS] == $past(rd_data[POS_SBS]));

    a_r4_write_loads: assert property (@(posedge clk) disable iff (rst_por || rst_sys)
        wr_en |=> (rd_data[POS_DS +: NUM_DS] == $past(wr_data[POS_DS +: NUM_DS]))
                  && (rd_data[POS_RUN] == $past(wr_data[POS_RUN])));

    a_r8_stop_set_wins: assert property (@(posedge clk) disable iff (rst_por || rst_sys)
        evt_stop |=> rd_data[POS_STOP]);

    a_r8_sbs_set_wins: assert property (@(posedge clk) disable iff (rst_por || rst_sys)
        evt_sbsys |=> rd_data[POS_SBS]);

    a_r9_clr_reads_zero: assert property (@(posedge clk)
        !rd_data[POS_CLR]);

    for (genvar i = 0; i < NUM_DSB; i++) begin : g_chk
        a_r7_hold_in_sb: assert property (@(posedge clk) disable iff (rst_por || rst_sys)
            (dom_in_sb[i] && rd_data[POS_SBD + i]) |=> rd_data[POS_SBD + i]);
        a_r5_dom_set: assert property (@(posedge clk) disable iff (rst_por || rst_sys)
            evt_sbdom[i] |=> rd_data[POS_SBD + i]);
    end
endmodule

bind cpupwr_lp_status cpupwr_lp_status_chk u_chk (.*);

// File: tb/sim_cpupwr_lp_status.sv
module sim_cpupwr_lp_status;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_por, rst_sys, wr_en, evt_stop, evt_sbsys;
    logic [31:0] wr_data;
    logic [1:0]  evt_sbdom, dom_in_sb;
    logic [31:0] rd_data;
    logic [2:0]  dsel_o;
    logic        d3_run_o;

    int errors = 0;
    int checks = 0;

    // behavioural reference state
    bit [2:0] m_ds;
    bit       m_run, m_stop, m_sbs;
    bit [1:0] m_sbd;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpupwr_lp_status u0 (
        .clk(clk), .rst_por(rst_por), .rst_sys(rst_sys), .wr_en(wr_en),
        .wr_data(wr_data), .evt_stop(evt_stop), .evt_sbsys(evt_sbsys),
        .evt_sbdom(evt_sbdom), .dom_in_sb(dom_in_sb), .rd_data(rd_data),
        .dsel_o(dsel_o), .d3_run_o(d3_run_o)
    );

    function automatic bit [31:0] expect_word();
        bit [31:0] w = 32'h0;
        w[2:0] = m_ds;
        w[5]   = m_stop;
        w[6]   = m_sbs;
        w[8:7] = m_sbd;
        w[11]  = m_run;
        return w;
    endfunction

    task automatic model_step();
        bit clr;
        if (rst_por) begin
            m_ds = 0; m_run = 0; m_stop = 0; m_sbs = 0; m_sbd = 0;
        end else if (rst_sys) begin
            m_ds = 0; m_run = 0; m_stop = 0; m_sbd = 0;
        end else begin
            clr = wr_en && wr_data[9];
            if (wr_en) begin
                m_ds  = wr_data[2:0];
                m_run = wr_data[11];
            end
            if (evt_stop) m_stop = 1; else if (clr) m_stop = 0;
            if (evt_sbsys) m_sbs = 1; else if (clr) m_sbs = 0;
            for (int i = 0; i < 2; i++) begin
                if (evt_sbdom[i]) m_sbd[i] = 1;
                else if (clr && !dom_in_sb[i]) m_sbd[i] = 0;
            end
        end
    endtask

    task automatic tick(input bit por, input bit sys, input bit we, input bit [31:0] wd,
                        input bit es, input bit ess, input bit [1:0] ed,
                        input bit [1:0] insb, input string tag);
        bit [31:0] exp;
        rst_por = por; rst_sys = sys; wr_en = we; wr_data = wd;
        evt_stop = es; evt_sbsys = ess; evt_sbdom = ed; dom_in_sb = insb;
        @(posedge clk);
        model_step();
        @(negedge clk);
        exp = expect_word();
        checks++;
        if (rd_data !== exp || dsel_o !== m_ds || d3_run_o !== m_run) begin
            errors++;
            $display("FAIL %s: rd_data=%h dsel=%b run=%b expected rd_data=%h dsel=%b run=%b",
                     tag, rd_data, dsel_o, d3_run_o, exp, m_ds, m_run);
        end
        checks++;
        if (rd_data[9] !== 1'b0) begin
            errors++;
            $display("FAIL R9: bit9=%b expected 0", rd_data[9]);
        end
    endtask

    task automatic idle(input bit [1:0] insb, input string tag);
        tick(0, 0, 0, 32'h0, 0, 0, 2'b00, insb, tag);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: power-on reset
        tick(1, 0, 0, 32'h0, 0, 0, 2'b00, 2'b00, "R1 por");
        tick(1, 0, 0, 32'h0, 1, 1, 2'b11, 2'b00, "R10 por ignores events");
        idle(2'b00, "R1 after por");

        // R4: selections load, flag bits and unused bits ignored
        tick(0, 0, 1, 32'h0000_0805, 0, 0, 2'b00, 2'b00, "R4 load sel");
        tick(0, 0, 1, 32'hFFFF_F1E2, 0, 0, 2'b00, 2'b00, "R4 flag bits ignored");
        tick(0, 0, 1, 32'h0000_0803, 0, 0, 2'b00, 2'b00, "R4 reload");

        // R5: events set flags
        tick(0, 0, 0, 32'h0, 1, 0, 2'b00, 2'b00, "R5 stop");
        tick(0, 0, 0, 32'h0, 0, 1, 2'b00, 2'b00, "R5 sbsys");
        tick(0, 0, 0, 32'h0, 0, 0, 2'b11, 2'b11, "R5 dom");

        // R6/R7: clear while both domains still in standby
        tick(0, 0, 1, 32'h0000_0200, 0, 0, 2'b00, 2'b11, "R6 R7 clear in sb");
        // R7: domain 0 leaves standby; dropped clear is not replayed
        idle(2'b10, "R7 no deferral");
        idle(2'b10, "R7 no deferral 2");
        tick(0, 0, 1, 32'h0000_0200, 0, 0, 2'b00, 2'b10, "R7 clear dom0 only");
        idle(2'b00, "R7 hold");
        tick(0, 0, 1, 32'h0000_0200, 0, 0, 2'b00, 2'b00, "R7 clear dom1");

        // R8: set wins over same-cycle clear
        tick(0, 0, 1, 32'h0000_0201, 1, 1, 2'b01, 2'b00, "R8 set wins");
        tick(0, 0, 1, 32'h0000_0200, 0, 0, 2'b10, 2'b00, "R8 partial");

        // R2/R3: system reset
        tick(0, 0, 0, 32'h0, 1, 1, 2'b11, 2'b00, "R5 set all");
        tick(0, 0, 1, 32'h0000_0807, 0, 0, 2'b00, 2'b00, "R4 set sel");
        tick(0, 1, 0, 32'h0, 0, 0, 2'b00, 2'b00, "R2 R3 sys reset");
        tick(0, 1, 1, 32'h0000_0A07, 1, 0, 2'b11, 2'b00, "R10 sys ignores events");
        idle(2'b00, "R3 sbs kept");
        tick(0, 1, 0, 32'h0, 0, 1, 2'b00, 2'b00, "R10 sbs event in sys reset");

        // R1: power-on reset clears surviving system standby flag
        tick(1, 0, 0, 32'h0, 0, 0, 2'b00, 2'b00, "R1 por clears sbs");
        idle(2'b00, "R1 idle");

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule